// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block collects nineteen asynchronous request lines and turns edges on them into latched interrupt requests and one-cycle event pulses. Lines 0 to 15 each take the same-numbered pin of one of several general-purpose ports, picked by a 4-bit port-select field per line. Lines 16, 17 and 18 take three internal request inputs. Every line passes through a two-flop synchronizer, and an edge detector compares the synchronized value with the value it held one cycle before.

Each line has its own rising-edge enable, falling-edge enable, interrupt mask, event mask, software trigger and pending flag. These are held in 32-bit registers on a simple synchronous register bus. Writes are captured on the clock edge and reads are combinational. Software sets a pending flag by writing 1 to the trigger register, and clears pending flags by writing 1 to them. A level interrupt request stays high for as long as a line is both pending and unmasked.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register (word addresses 0 to 15) reads zero, and `irq_o` and `evt_o` are zero. Port 0 is therefore selected for every pin line.
- R2: Suppose a line input changes between two clock edges, and the selected edge type is enabled. The line's pending bit (register 5) is set on the third following rising clock edge, and not before.
- R3: Rising enables are in register 2 and falling enables in register 3, with bit n for line n. An edge whose type is not enabled leaves the pending bit clear. With both enables set, either transition sets the bit. A static level never sets a pending bit.
- R4: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves the bit unchanged.
- R5: If an enabled edge and a write-1 clear reach the same line on the same clock edge, the pending bit stays set.
- R6: `irq_o[n]` is high exactly when pending bit n and interrupt mask bit n (register 0) are both 1.
- R7: For a line whose event mask bit (register 1) is set, an enabled edge or a software trigger produces a pulse on `evt_o[n]` that lasts exactly one cycle. The pulse appears on the same clock edge that sets the pending bit. The interrupt mask does not affect it, and with the event mask clear there is no pulse.
- R8: Writing 1 to bit n of the software trigger register (register 4) sets that bit and pending bit n. Writing 0 has no effect. The trigger bit clears itself when pending bit n is cleared.
- R9: In registers 0 to 5, only bits 18:0 exist. In registers 6 to 9, only bits 15:0 exist. Unused bits read zero and ignore writes, and addresses 10 to 15 read zero.
- R10: Pin line n (0 to 15) takes pin n of the port held in the field at bits 4(n mod 4)+3 : 4(n mod 4) of register 6 + n/4. Pins of other ports have no effect. A select value at or above the port count gives a constant low input.
- R11: Lines 16, 17 and 18 are driven by `int_req[0]`, `int_req[1]` and `int_req[2]`, and they follow the same edge and pending rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_pins | input | NUM_PORTS*16 | Port pins; pin n of port p at bit p*16+n |
| int_req | input | 3 | Internal request inputs for lines 16 to 18 |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write enable, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 19 | Level interrupt request per line |
| evt_o | output | 19 | One-cycle event pulse per line |

## Verification
A rising-edge sweep visits all nineteen lines in turn. A pending bit on any line other than the one driven exposes a crossed line or a wrong internal mapping. The port sweep tries every select value, including one past the last port, on every pin line. It toggles the unselected ports first and then the selected one, which separates a correct field layout from a shifted or misdecoded one. Single-line sequences cover the remaining cases:
- rise-only, fall-only and any-edge enables, plus a held level;
- a clear that lands on the same edge that sets the bit;
- event pulses with the interrupt mask off;
- software triggers.

Between them these tell apart a wrong edge polarity, a lost pending bit, an overlong pulse and a trigger bit that does not self-clear.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int unsigned LINES       = 19;
    localparam int unsigned PIN_LINES   = 16;
    localparam int unsigned INT_LINES   = LINES - PIN_LINES;
    localparam int unsigned SEL_W       = 4;
    localparam int unsigned SEL_PER_REG = 4;
    localparam int unsigned SEL_REGS    = PIN_LINES / SEL_PER_REG;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 4;

    typedef logic [LINES-1:0] line_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_IMASK = 4'd0,
        REG_EMASK = 4'd1,
        REG_RISE  = 4'd2,
        REG_FALL  = 4'd3,
        REG_SWT   = 4'd4,
        REG_PEND  = 4'd5,
        REG_SEL0  = 4'd6
    } reg_addr_e;

    typedef struct packed {
        line_vec_t imask;
        line_vec_t emask;
        line_vec_t rise;
        line_vec_t fall;
    } line_cfg_t;

    function automatic line_vec_t bus_lines(input logic [DATA_W-1:0] d);
        return d[LINES-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] lines_to_bus(input line_vec_t v);
        return {{(DATA_W-LINES){1'b0}}, v};
    endfunction

endpackage

// File: rtl/extint_port_mux.sv
module extint_port_mux
    import extint_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 7
) (
    input  logic [NUM_PORTS*PIN_LINES-1:0] pins,
    input  logic [PIN_LINES*SEL_W-1:0]     sel_flat,
    output logic [PIN_LINES-1:0]           line_in
);

    for (genvar n = 0; n < PIN_LINES; n++) begin : g_line
        always_comb begin
            line_in[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel_flat[n*SEL_W +: SEL_W] == SEL_W'(p)) begin
                    line_in[n] = pins[p*PIN_LINES + n];
                end
            end
        end
    end

endmodule

// File: rtl/extint_edge.sv
module extint_edge
    import extint_pkg::*;
#(
    parameter int unsigned WIDTH = LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign hit = (sync_q & ~prev_q & rise_en) | (~sync_q & prev_q & fall_en);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS*PIN_LINES-1:0] gpio_pins,
    input  logic [INT_LINES-1:0]           int_req,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_we,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic [LINES-1:0]               irq_o,
    output logic [LINES-1:0]               evt_o
);

    localparam int unsigned SEL_BITS = SEL_W * SEL_PER_REG;

    line_cfg_t  cfg;
    line_vec_t  swt, pend, evt_q;
    line_vec_t  hit, sw_set, clr_vec, pend_n;
    logic [SEL_W-1:0]           psel [PIN_LINES];
    logic [PIN_LINES*SEL_W-1:0] psel_flat;
    logic [PIN_LINES-1:0]       pin_line;
    line_vec_t                  raw_in;
    logic                       unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:LINES];

    for (genvar n = 0; n < PIN_LINES; n++) begin : g_flat
        assign psel_flat[n*SEL_W +: SEL_W] = psel[n];
    end

    extint_port_mux #(.NUM_PORTS(NUM_PORTS)) i_mux (
        .pins     (gpio_pins),
        .sel_flat (psel_flat),
        .line_in  (pin_line)
    );

    assign raw_in = {int_req, pin_line};

    extint_edge #(.WIDTH(LINES)) i_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_in),
        .rise_en  (cfg.rise),
        .fall_en  (cfg.fall),
        .hit      (hit)
    );

    assign sw_set  = (reg_we && reg_addr == REG_SWT)  ? bus_lines(reg_wdata) : '0;
    assign clr_vec = (reg_we && reg_addr == REG_PEND) ? bus_lines(reg_wdata) : '0;
    assign pend_n  = (pend & ~clr_vec) | hit | sw_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            swt   <= '0;
            pend  <= '0;
            evt_q <= '0;
            for (int n = 0; n < PIN_LINES; n++) psel[n] <= '0;
        end else begin
            pend  <= pend_n;
            swt   <= (swt | sw_set) & pend_n;
            evt_q <= (hit | sw_set) & cfg.emask;
            if (reg_we) begin
                case (reg_addr)
                    REG_IMASK: cfg.imask <= bus_lines(reg_wdata);
                    REG_EMASK: cfg.emask <= bus_lines(reg_wdata);
                    REG_RISE:  cfg.rise  <= bus_lines(reg_wdata);
                    REG_FALL:  cfg.fall  <= bus_lines(reg_wdata);
                    default: ;
                endcase
                for (int k = 0; k < SEL_REGS; k++) begin
                    if (reg_addr == ADDR_W'(REG_SEL0) + ADDR_W'(k)) begin
                        for (int j = 0; j < SEL_PER_REG; j++) begin
                            psel[k*SEL_PER_REG + j] <= reg_wdata[j*SEL_W +: SEL_W];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_IMASK: reg_rdata = lines_to_bus(cfg.imask);
            REG_EMASK: reg_rdata = lines_to_bus(cfg.emask);
            REG_RISE:  reg_rdata = lines_to_bus(cfg.rise);
            REG_FALL:  reg_rdata = lines_to_bus(cfg.fall);
            REG_SWT:   reg_rdata = lines_to_bus(swt);
            REG_PEND:  reg_rdata = lines_to_bus(pend);
            default: ;
        endcase
        for (int k = 0; k < SEL_REGS; k++) begin
            if (reg_addr == ADDR_W'(REG_SEL0) + ADDR_W'(k)) begin
                for (int j = 0; j < SEL_PER_REG; j++) begin
                    reg_rdata[j*SEL_W +: SEL_W] = psel[k*SEL_PER_REG + j];
                end
            end
        end
        reg_rdata[DATA_W-1:SEL_BITS] = (reg_addr < ADDR_W'(REG_SEL0)) ?
                                       reg_rdata[DATA_W-1:SEL_BITS] : '0;
    end

    assign irq_o = pend & cfg.imask;
    assign evt_o = evt_q;

    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend) & ~$past(hit | sw_set)) == '0));            // R2
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((~pend & $past(pend & ~clr_vec)) == '0));                        // R4
    AST_CLEAR_LOSES_TO_EDGE: assert property (@(posedge clk) disable iff (rst)
        ((~pend & $past(hit & clr_vec)) == '0));                          // R5
    AST_EVT_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        ((evt_o & ~$past(cfg.emask)) == '0));                             // R7
    AST_SWT_INSIDE_PEND: assert property (@(posedge clk) disable iff (rst)
        ((swt & ~pend) == '0));                                           // R8

endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NPORTS     = 7;
    localparam int NL         = 19;
    localparam logic [31:0] ALL = 32'h0007_FFFF;

    logic clk = 1'b0;
    logic rst;
    logic [NPORTS*16-1:0] gpio;
    logic [2:0]  ireq;
    logic [3:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [NL-1:0] irq, evt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl #(.NUM_PORTS(NPORTS)) i_extint_ctrl (
        .clk(clk), .rst(rst), .gpio_pins(gpio), .int_req(ireq),
        .reg_addr(addr), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq_o(irq), .evt_o(evt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(a);
        #1 d = rdata;
    endtask

    task automatic drive(input int l, input int p, input logic v);
        if (l < 16) gpio[p*16 + l] = v;
        else        ireq[l-16] = v;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cnt, at;
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; gpio = '0; ireq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check($sformatf("R1 reg %0d", a), v, 32'h0);
        end
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 evt", 32'(evt), 32'h0);

        // R9 unused bits
        wr(0, 32'hFFFF_FFFF); rd(0, v); check("R9 imask width", v, ALL);
        wr(6, 32'hFFFF_FFFF); rd(6, v); check("R9 select width", v, 32'h0000_FFFF);
        wr(6, 32'h0); rd(12, v); check("R9 unmapped", v, 32'h0);

        // R2 latency on line 0 (rise only, imask all)
        wr(2, ALL);
        @(negedge clk) drive(0, 0, 1'b1);
        @(negedge clk);
        @(negedge clk) check("R2 not before third edge", 32'(irq[0]), 32'h0);
        @(negedge clk) check("R2 set on third edge", 32'(irq[0]), 32'h1);
        wr(5, ALL);
        @(negedge clk) drive(0, 0, 1'b0);
        settle();

        // R2 R6 R11 R3 sweep of every line, rising only
        for (int l = 0; l < NL; l++) begin
            @(negedge clk) drive(l, 0, 1'b1);
            settle();
            rd(5, v);
            check($sformatf("R2 R11 line %0d pending", l), v, 32'(1) << l);
            check($sformatf("R6 line %0d irq", l), 32'(irq), 32'(1) << l);
            wr(5, 32'(1) << l);
            rd(5, v);
            check($sformatf("R4 line %0d cleared", l), v, 32'h0);
            @(negedge clk) drive(l, 0, 1'b0);
            settle();
            rd(5, v);
            check($sformatf("R3 line %0d fall ignored", l), v, 32'h0);
        end

        // R6 masked line keeps irq low
        wr(0, ALL & ~32'h8);
        @(negedge clk) drive(3, 0, 1'b1);
        settle();
        check("R6 masked irq", 32'(irq), 32'h0);
        wr(0, ALL);
        check("R6 unmasked irq", 32'(irq), 32'h8);
        wr(5, ALL);
        @(negedge clk) drive(3, 0, 1'b0);
        settle();

        // R3 any-edge, fall-only, static level
        wr(3, 32'h8);
        @(negedge clk) drive(3, 0, 1'b1);
        settle(); rd(5, v); check("R3 any-edge rise", v, 32'h8);
        wr(5, 32'h8);
        @(negedge clk) drive(3, 0, 1'b0);
        settle(); rd(5, v); check("R3 any-edge fall", v, 32'h8);
        wr(5, ALL);
        wr(2, 32'h0);
        @(negedge clk) drive(3, 0, 1'b1);
        settle(); rd(5, v); check("R3 fall-only ignores rise", v, 32'h0);
        @(negedge clk) drive(3, 0, 1'b0);
        settle(); rd(5, v); check("R3 fall-only fires", v, 32'h8);
        wr(5, ALL);
        repeat (12) @(negedge clk);
        rd(5, v); check("R3 static level", v, 32'h0);

        // R4 writing zero keeps pending
        @(negedge clk) drive(3, 0, 1'b1);
        @(negedge clk) drive(3, 0, 1'b0);
        settle();
        wr(5, 32'h0); rd(5, v); check("R4 write zero", v, 32'h8);

        // R5 edge and clear on the same edge (line 3 any edge, already pending)
        wr(2, 32'h8);
        @(negedge clk) drive(3, 0, 1'b1);
        @(negedge clk);
        @(negedge clk) begin we = 1'b1; addr = 4'd5; wdata = 32'h8; end
        @(negedge clk) we = 1'b0;
        rd(5, v); check("R5 edge beats clear", v, 32'h8);
        wr(5, 32'h8); rd(5, v); check("R5 plain clear", v, 32'h0);
        @(negedge clk) drive(3, 0, 1'b0);
        settle(); wr(5, ALL);

        // R7 event pulse on line 5, interrupt mask off
        wr(0, 32'h0); wr(3, 32'h0); wr(2, 32'h20); wr(1, 32'h20);
        @(negedge clk) drive(5, 0, 1'b1);
        cnt = 0; at = -1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (evt[5]) begin cnt++; if (at < 0) at = i; end
        end
        check("R7 one pulse", 32'(cnt), 32'd1);
        check("R7 pulse cycle", 32'(at), 32'd2);
        check("R7 no irq", 32'(irq), 32'h0);
        wr(5, ALL);
        @(negedge clk) drive(5, 0, 1'b0);
        settle();
        wr(1, 32'h0);
        @(negedge clk) drive(5, 0, 1'b1);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (evt[5]) cnt++;
        end
        check("R7 masked no pulse", 32'(cnt), 32'd0);
        rd(5, v); check("R7 pending still set", v, 32'h20);
        wr(5, ALL);
        @(negedge clk) drive(5, 0, 1'b0);
        settle();

        // R8 software trigger, with event mask on line 17
        wr(0, ALL); wr(1, 32'h2_0000);
        wr(4, 32'h2_0000);
        check("R7 software event", 32'(evt), 32'h2_0000);
        @(negedge clk) check("R7 software event ends", 32'(evt), 32'h0);
        rd(4, v); check("R8 trigger reads set", v, 32'h2_0000);
        rd(5, v); check("R8 pending set", v, 32'h2_0000);
        check("R8 irq", 32'(irq), 32'h2_0000);
        wr(4, 32'h0); rd(4, v); check("R8 write zero", v, 32'h2_0000);
        wr(5, 32'h2_0000);
        rd(4, v); check("R8 self clear", v, 32'h0);
        rd(5, v); check("R8 pending clear", v, 32'h0);
        wr(1, 32'h0); wr(2, ALL); wr(0, 32'h0);

        // R10 port select sweep, one past the last port included
        for (int l = 0; l < 16; l++) begin
            for (int p = 0; p <= NPORTS; p++) begin
                logic [31:0] word;
                word = 32'(p) << (4*(l%4));
                wr(6 + l/4, word);
                rd(6 + l/4, v);
                check($sformatf("R10 line %0d port %0d field", l, p), v, word);
                settle(); wr(5, ALL);
                @(negedge clk);
                for (int q = 0; q < NPORTS; q++) if (q != p) gpio[q*16 + l] = 1'b1;
                settle(); rd(5, v);
                check($sformatf("R10 line %0d port %0d others", l, p), v, 32'h0);
                @(negedge clk) gpio = '0;
                settle(); wr(5, ALL);
                @(negedge clk) if (p < NPORTS) gpio[p*16 + l] = 1'b1;
                settle(); rd(5, v);
                check($sformatf("R10 line %0d port %0d chosen", l, p), v,
                      (p < NPORTS) ? (32'(1) << l) : 32'h0);
                @(negedge clk) gpio = '0;
                wr(6 + l/4, 32'h0);
                settle(); wr(5, ALL);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule